// File: doc/BRIEF.md
# Multi-source reset and reboot controller

This block merges five asynchronous power-on class reset requests into one application reset and one debug-domain reset. The sources are power supervision, power control, an external active-low reset pin, an oscillator resistor fault from the clock system, and the debug port. Every request is synchronised so that the resets assert at once and release on a clock edge. After the last request drops, each source holds the resets for its own number of cycles, so the recovery delay can be tuned per source.

Software can also start a reboot through a 32-bit write-only control word. A reboot resets the application exactly as a power-on class reset does, but it leaves the debug domain running, so an attached debugger stays connected. A sticky cause code records which event produced the most recent reset.

Top module: `rst_reboot_ctrl`

## Requirements
- R1: After `rst_ni` releases, `app_rst_no` and `dbg_rst_no` are 1, `cause_o` is 0 and `reg_rdata_o` is 0.
- R2: Any of the five requests (`sup_req_i`, `pwr_req_i`, `clk_fault_i`, `dbg_req_i` high, or `pin_rst_ni` low) drives both `app_rst_no` and `dbg_rst_no` to 0 without waiting for a clock edge.
- R3: When the last request is removed between edges, both resets return to 1 after the (HOLD+2)-th rising edge: two synchroniser stages, then HOLD cycles. Defaults: HOLD_SUP=16, HOLD_PWR=12, HOLD_PIN=8, HOLD_CLK=10, HOLD_DBG=6.
- R4: `cause_o` codes are: 1 supervision, 2 power control, 3 pin, 4 clock fault, 5 debug, 6 reboot. When several requests are active together, the lowest code wins and its hold count applies.
- R5: A write in which bits 15:8 equal 0x69 and bit 0 is 1 starts a reboot when no reset is active. `app_rst_no` goes low after that edge and returns high after the (HOLD_RBT+1)-th edge counted from the write edge (default HOLD_RBT=4). `dbg_rst_no` stays 1 and `cause_o` becomes 6. Bits 31:16 and 7:1 do not matter.
- R6: A write with bits 15:8 not equal to 0x69, or with bit 0 equal to 0, leaves both resets and `cause_o` unchanged.
- R7: A valid reboot write made while a reset is active is dropped. It neither lengthens that reset nor starts a later reboot.
- R8: A power-on class request that arrives during a reboot also asserts `dbg_rst_no` and sets `cause_o` to its own code.
- R9: `reg_rdata_o` reads 0 at all times.
- R10: `cause_o` keeps its value after the resets release, until the next reset event or `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Always-on domain reset, active low, asynchronous |
| pin_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| sup_req_i | input | 1 | Power supervision reset request, asynchronous |
| pwr_req_i | input | 1 | Power control reset request, asynchronous |
| clk_fault_i | input | 1 | Oscillator resistor fault reset request, asynchronous |
| dbg_req_i | input | 1 | Debug port reset request, asynchronous |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Control word read data |
| app_rst_no | output | 1 | Application reset, active low |
| dbg_rst_no | output | 1 | Debug-domain reset, active low |
| cause_o | output | 3 | Sticky cause of the last reset |

## Verification
A corrupted hold counter appears directly as a release edge that comes early or late, so the bench counts the exact number of rising edges before each reset returns high. A wrong mode flag, such as a reboot state left set or a reboot taken while a power-on reset is active, shows within one cycle. It appears either as `dbg_rst_no` low while the cause code is 6, or as `app_rst_no` low again after a release. A wrong priority shows at the first edge of a multi-source request as an unexpected cause code, and later as a hold length that belongs to a different source.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  localparam int NSRC = 5;
  localparam logic [7:0] KEY_VAL = 8'h69;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_SUP    = 3'd1,
    CAUSE_PWR    = 3'd2,
    CAUSE_PIN    = 3'd3,
    CAUSE_CLKF   = 3'd4,
    CAUSE_DBG    = 3'd5,
    CAUSE_REBOOT = 3'd6
  } cause_e;
endpackage

// File: rtl/rrc_req_sync.sv
// Asynchronous assert, synchronous two-stage release.
module rrc_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic req_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni or posedge req_i) begin
    if (!rst_ni)     q <= '0;
    else if (req_i)  q <= '1;
    else             q <= {q[STAGES-2:0], 1'b0};
  end

  assign req_o = q[STAGES-1];

  p_sync_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> !req_i);
endmodule

// File: rtl/rrc_hold_timer.sv
module rrc_hold_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             en_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt <= '0;
    else if (load_i)                  cnt <= load_val_i;
    else if (en_i && cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign done_o = (cnt <= CNT_W'(1));

  p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !en_i) |=> $stable(done_o));
  p_hold_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i > CNT_W'(1)) |=> !done_o);
endmodule

// File: rtl/rrc_key_reg.sv
module rrc_key_reg (
  input  logic        wr_i,
  input  logic [7:0]  key_i,
  input  logic        trig_i,
  output logic        reboot_o,
  output logic [31:0] rdata_o
);
  import rrc_pkg::*;

  assign reboot_o = wr_i && trig_i && (key_i == KEY_VAL);
  assign rdata_o  = '0;  // all fields write-only or reserved
endmodule

// File: rtl/rst_reboot_ctrl.sv
module rst_reboot_ctrl
  import rrc_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int HOLD_SUP = 16,
  parameter int HOLD_PWR = 12,
  parameter int HOLD_PIN = 8,
  parameter int HOLD_CLK = 10,
  parameter int HOLD_DBG = 6,
  parameter int HOLD_RBT = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pin_rst_ni,
  input  logic        sup_req_i,
  input  logic        pwr_req_i,
  input  logic        clk_fault_i,
  input  logic        dbg_req_i,
  input  logic        reg_wr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        app_rst_no,
  output logic        dbg_rst_no,
  output logic [2:0]  cause_o
);
  localparam int HOLD_TAB [NSRC] = '{HOLD_SUP, HOLD_PWR, HOLD_PIN, HOLD_CLK, HOLD_DBG};

  logic [NSRC-1:0] req_raw, req_s;
  logic            any_req, rbt_go, tmr_done, tmr_load, tmr_en;
  logic            por_act, rbt_act;
  logic [CNT_W-1:0] tmr_val;
  logic [2:0]      sel_idx;
  cause_e          cause_q;
  logic            unused_wdata;

  // index order is the priority order (0 highest)
  assign req_raw = {dbg_req_i, clk_fault_i, ~pin_rst_ni, pwr_req_i, sup_req_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_sync
    rrc_req_sync #(.STAGES(2)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (req_raw[g]),
      .req_o (req_s[g])
    );
  end

  assign any_req = |req_s;

  always_comb begin
    sel_idx = 3'd0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_s[i]) sel_idx = 3'(i);
    end
  end

  rrc_key_reg u_key (
    .wr_i    (reg_wr_i),
    .key_i   (reg_wdata_i[15:8]),
    .trig_i  (reg_wdata_i[0]),
    .reboot_o(rbt_go),
    .rdata_o (reg_rdata_o)
  );
  assign unused_wdata = ^{reg_wdata_i[31:16], reg_wdata_i[7:1]};

  assign tmr_load = any_req || (rbt_go && !por_act && !rbt_act);
  assign tmr_val  = any_req ? CNT_W'(HOLD_TAB[sel_idx]) : CNT_W'(HOLD_RBT);
  assign tmr_en   = por_act || rbt_act;

  rrc_hold_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .en_i      (tmr_en),
    .done_o    (tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_act <= 1'b0;
      rbt_act <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else if (any_req) begin
      por_act <= 1'b1;
      rbt_act <= 1'b0;
      cause_q <= cause_e'(sel_idx + 3'd1);
    end else if (rbt_go && !por_act && !rbt_act) begin
      rbt_act <= 1'b1;
      cause_q <= CAUSE_REBOOT;
    end else if (tmr_en && tmr_done) begin
      por_act <= 1'b0;
      rbt_act <= 1'b0;
    end
  end

  // assertion is combinational through the synchronisers
  assign app_rst_no = ~(any_req | por_act | rbt_act);
  assign dbg_rst_no = ~(any_req | por_act);
  assign cause_o    = cause_q;

  p_dbg_implies_app_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_rst_no |-> !app_rst_no);
  p_reboot_keeps_dbg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!app_rst_no && dbg_rst_no) |-> (cause_o == CAUSE_REBOOT));
  p_valid_key_starts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[15:8] == KEY_VAL && reg_wdata_i[0] && app_rst_no) |=> !app_rst_no);
  p_bad_key_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[15:8] != KEY_VAL && app_rst_no) |=> (app_rst_no || $countones(req_s) != 0));
  p_release_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(app_rst_no) |-> $past(tmr_done));
  p_cause_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (app_rst_no && !rbt_go) |=> $stable(cause_o));
endmodule

// File: tb/rst_reboot_ctrl_tb_top.sv
module rst_reboot_ctrl_tb_top;
  localparam int H_SUP = 16, H_PWR = 12, H_PIN = 8, H_CLK = 10, H_DBG = 6, H_RBT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_n = 1'b1, sup = 1'b0, pwr = 1'b0, cfault = 1'b0, dbg = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        app_n, dbg_n;
  logic [2:0]  cause;
  int          checks = 0, fails = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  rst_reboot_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_rst_ni(pin_n), .sup_req_i(sup),
    .pwr_req_i(pwr), .clk_fault_i(cfault), .dbg_req_i(dbg),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .app_rst_no(app_n), .dbg_rst_no(dbg_n), .cause_o(cause)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts rising edges until app reset reads high at a falling edge
  task automatic count_release(output int n);
    n = 0;
    while (!app_n && n < 200) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    wr = 1'b1; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(app_n == 1'b1, "R1 app", app_n, 1);
    chk(dbg_n == 1'b1, "R1 dbg", dbg_n, 1);
    chk(cause == 3'd0, "R1 cause", cause, 0);
    chk(rdata == 32'd0, "R1 rdata", rdata, 0);
  endtask

  // idx: 1 sup,2 pwr,3 pin,4 clk,5 dbg
  task automatic set_src(input int idx, input logic v);
    case (idx)
      1: sup = v;
      2: pwr = v;
      3: pin_n = ~v;
      4: cfault = v;
      default: dbg = v;
    endcase
  endtask

  task automatic t_source(input int idx, input int hold);
    int n;
    @(negedge clk);
    set_src(idx, 1'b1);
    #1;
    chk(app_n == 1'b0 && dbg_n == 1'b0, "R2 async assert", {app_n, dbg_n}, 0);
    repeat (3) @(negedge clk);
    chk(cause == 3'(idx), "R4 cause code", cause, idx);
    set_src(idx, 1'b0);
    count_release(n);
    chk(n == hold + 2, "R3 hold length", n, hold + 2);
    chk(dbg_n == 1'b1, "R3 dbg release", dbg_n, 1);
    repeat (3) @(negedge clk);
    chk(cause == 3'(idx), "R10 cause sticky", cause, idx);
  endtask

  task automatic t_priority;
    int n;
    @(negedge clk);
    sup = 1'b1; dbg = 1'b1;
    repeat (3) @(negedge clk);
    chk(cause == 3'd1, "R4 priority cause", cause, 1);
    sup = 1'b0; dbg = 1'b0;
    count_release(n);
    chk(n == H_SUP + 2, "R4 priority hold", n, H_SUP + 2);
  endtask

  task automatic t_reboot;
    int n;
    @(negedge clk);
    do_write(32'hFFFF_69FF);
    chk(app_n == 1'b0, "R5 app low", app_n, 0);
    chk(dbg_n == 1'b1, "R5 dbg kept", dbg_n, 1);
    chk(cause == 3'd6, "R5 cause", cause, 6);
    chk(rdata == 32'd0, "R9 rdata", rdata, 0);
    count_release(n);
    chk(n + 1 == H_RBT + 1, "R5 reboot length", n + 1, H_RBT + 1);
  endtask

  task automatic t_bad_writes;
    @(negedge clk);
    do_write(32'h0000_6801);
    repeat (2) @(negedge clk);
    chk(app_n == 1'b1 && dbg_n == 1'b1, "R6 bad key", {app_n, dbg_n}, 3);
    do_write(32'h0000_6900);
    repeat (2) @(negedge clk);
    chk(app_n == 1'b1, "R6 trigger zero", app_n, 1);
    chk(cause == 3'd6, "R6 cause unchanged", cause, 6);
    chk(rdata == 32'd0, "R9 rdata after writes", rdata, 0);
  endtask

  task automatic t_absorb;
    int n;
    @(negedge clk);
    pin_n = 1'b0;
    repeat (2) @(negedge clk);
    do_write(32'h0000_6901);
    chk(cause == 3'd3, "R7 cause kept", cause, 3);
    pin_n = 1'b1;
    count_release(n);
    chk(n == H_PIN + 2, "R7 no extension", n, H_PIN + 2);
    repeat (H_RBT + 4) @(negedge clk);
    chk(app_n == 1'b1, "R7 not queued", app_n, 1);
  endtask

  task automatic t_por_in_reboot;
    int n;
    @(negedge clk);
    do_write(32'h0000_6901);
    cfault = 1'b1;
    #1;
    chk(dbg_n == 1'b0, "R8 dbg asserted", dbg_n, 0);
    @(negedge clk);
    chk(cause == 3'd4, "R8 cause", cause, 4);
    cfault = 1'b0;
    count_release(n);
    chk(n == H_CLK + 2, "R8 hold", n, H_CLK + 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_source(1, H_SUP);
    t_source(2, H_PWR);
    t_source(3, H_PIN);
    t_source(4, H_CLK);
    t_source(5, H_DBG);
    t_priority();
    t_reboot();
    t_bad_writes();
    t_absorb();
    t_por_in_reboot();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule